// File: doc/BRIEF.md
# Register-Driven I2C Byte Master

This block is a single-master I2C controller that a processor steers one bus step at a time through four byte-wide registers. Software picks the step in a control word: a START (or repeated START), one byte moved on the bus, or a STOP. Writing that word with the completion flag bit set launches the step. The block then runs SCL and SDA as open-drain lines: it drives output enables and samples SDA. When the step is done it sets the completion flag again and posts an 8-bit status code for the event. Software polls the flag or takes the interrupt, reads the status, and launches the next step.

The first byte after a START is the address byte: the 7-bit slave address sits in bits 7:1 and the direction sits in bit 0, where 0 means write and 1 means read. That bit decides whether the following bytes are sent or received. For each received byte, an acknowledge-enable bit chooses whether the master answers with ACK or NACK.

Top module: `i2c_byte_master`

## Requirements
- R1: Register offsets are 0 = bit-rate, 1 = status, 2 = data, 3 = control. Writing the control register with bit 7 = 1 and bit 2 = 1 while no step is running launches a step: START if bit 5 is set, otherwise STOP if bit 4 is set, otherwise a byte transfer that sends the data register (or receives in read mode).
- R2: A launching write clears the completion flag (control bit 7). The flag reads 1 again exactly N*H + 1 cycles after the edge that took the write, with N = 3 for START and STOP and N = 18 for a byte. A control write with bit 7 = 0 leaves the flag unchanged.
- R3: The half-period is H = 8 + rate * P clock cycles, where P is 1, 4, 16 or 64 for status bits 1:0 = 0, 1, 2, 3. During a byte, each SCL high time lasts H cycles.
- R4: Status reads as {code[7:3], 0, prescaler[1:0]}. The code is 0xF8 after reset and after a STOP, 0x08 after a START, 0x18 or 0x20 after a write address that is ACKed or NACKed, and 0x28 or 0x30 after a sent data byte that is ACKed or NACKed.
- R5: After an address byte with bit 0 = 1, the code is 0x40 if the slave ACKs and 0x48 if it NACKs. An ACKed read address makes the following bytes receive transfers.
- R6: A received byte drives ACK (SDA low) in the ninth bit if control bit 6 was 1 in the launching write, and NACK otherwise, giving code 0x50 or 0x58. The byte is in the data register no later than the cycle in which the flag sets.
- R7: The interrupt output is high exactly when the completion flag and control bit 0 are both 1.
- R8: Writes to the data register while a step runs are ignored.
- R9: A control write with bit 2 = 0 stops any running step, releases both lines from the next cycle on, and no completion follows.
- R10: SDA changes while SCL is high only as a START (falling) or a STOP (rising). Each START step produces one such fall and each STOP step one such rise.
- R11: After reset, the registers read bit-rate 0, status 0xF8, data 0, control 0. Both lines are released and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following. The flag rises only after an engine completion, and every completion sets it. The data register holds still while a step runs. Both lines are released while the interface is disabled. The engine moves SDA under a high SCL only in the START and STOP phases. Only the scenarios can show the rest: that each status code is right for a given slave response, the exact completion latency for a given bit rate and prescaler, the bytes a slave actually sees, the ACK or NACK driven on received bytes, and that an aborted step never completes.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int REG_W   = 8;
    localparam int PRESC_W = 2;

    localparam logic [1:0] ADR_RATE = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_DATA = 2'd2;
    localparam logic [1:0] ADR_CTRL = 2'd3;

    localparam int B_FLAG  = 7;
    localparam int B_ACKEN = 6;
    localparam int B_STA   = 5;
    localparam int B_STO   = 4;
    localparam int B_EN    = 2;
    localparam int B_IE    = 0;

    localparam logic [7:0] SC_START = 8'h08;
    localparam logic [7:0] SC_IDLE  = 8'hF8;

    typedef enum logic [1:0] {ACT_START, ACT_STOP, ACT_BYTE} act_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HOLD,
        ST_SA, ST_SB, ST_SC,
        ST_BL, ST_BH,
        ST_PA, ST_PB, ST_PC
    } eng_st_e;

    typedef struct packed {
        logic acken;
        logic sta;
        logic sto;
        logic en;
        logic ie;
    } ctrl_t;

    function automatic logic [7:0] byte_code(input logic is_addr, input logic rd, input logic ack);
        logic [7:0] c;
        if (is_addr)  c = rd ? (ack ? 8'h40 : 8'h48) : (ack ? 8'h18 : 8'h20);
        else if (rd)  c = ack ? 8'h50 : 8'h58;
        else          c = ack ? 8'h28 : 8'h30;
        return c;
    endfunction

endpackage

// File: rtl/i2cm_half_timer.sv
module i2cm_half_timer #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             mid,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    assign last = run && (cnt == half - CNT_W'(1));
    assign mid  = run && (cnt == (half >> 1));

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (last)   cnt <= '0;
        else             cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine import i2cm_pkg::*; #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             go,
    input  act_e             act,
    input  logic [7:0]       tx_byte,
    input  logic             rx_mode,
    input  logic             ack_en,
    input  logic [CNT_W-1:0] half,
    input  logic             sda_in,
    output logic             done,
    output logic             ack_seen,
    output logic [7:0]       rx_byte,
    output logic             scl_oe,
    output logic             sda_oe
);
    eng_st_e    st;
    logic [3:0] bit_idx;
    logic [7:0] sh;
    logic       rxm_q, acken_q, scl_low, sda_low, done_q, ack_q;
    logic       run, mid, last, drive;

    assign run      = (st != ST_IDLE) && (st != ST_HOLD);
    assign drive    = (bit_idx == 4'd8) ? (rxm_q && acken_q) : (!rxm_q && !sh[7]);
    assign done     = done_q;
    assign ack_seen = ack_q;
    assign rx_byte  = sh;
    assign scl_oe   = scl_low;
    assign sda_oe   = sda_low;

    i2cm_half_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst || abort), .run(run), .half(half), .mid(mid), .last(last)
    );

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st <= ST_IDLE; bit_idx <= '0; sh <= '0;
            rxm_q <= 1'b0; acken_q <= 1'b0; ack_q <= 1'b0;
            scl_low <= 1'b0; sda_low <= 1'b0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE, ST_HOLD: if (go) begin
                    scl_low <= 1'b1;
                    unique case (act)
                        ACT_START: st <= ST_SA;
                        ACT_STOP:  st <= ST_PA;
                        default: begin
                            st <= ST_BL; bit_idx <= '0; sh <= tx_byte;
                            rxm_q <= rx_mode; acken_q <= ack_en;
                        end
                    endcase
                end
                ST_SA: begin
                    if (mid) sda_low <= 1'b0;
                    if (last) begin scl_low <= 1'b0; st <= ST_SB; end
                end
                ST_SB: if (last) begin sda_low <= 1'b1; st <= ST_SC; end
                ST_SC: if (last) begin scl_low <= 1'b1; st <= ST_HOLD; done_q <= 1'b1; end
                ST_BL: begin
                    if (mid) sda_low <= drive;
                    if (last) begin scl_low <= 1'b0; st <= ST_BH; end
                end
                ST_BH: if (last) begin
                    scl_low <= 1'b1;
                    if (bit_idx == 4'd8) begin
                        ack_q <= !sda_in; done_q <= 1'b1; st <= ST_HOLD;
                    end else begin
                        sh <= {sh[6:0], sda_in}; bit_idx <= bit_idx + 4'd1; st <= ST_BL;
                    end
                end
                ST_PA: begin
                    if (mid) sda_low <= 1'b1;
                    if (last) begin scl_low <= 1'b0; st <= ST_PB; end
                end
                ST_PB: if (last) begin sda_low <= 1'b0; st <= ST_PC; end
                ST_PC: if (last) begin st <= ST_IDLE; done_q <= 1'b1; end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R10: SDA may move under a released SCL only in the START/STOP edge phases
    p_sda_move_r10: assert property (@(posedge clk) disable iff (rst)
        (!scl_low && $past(!scl_low) && (sda_low != $past(sda_low)))
            |-> (st == ST_SC || st == ST_PC || $past(abort)));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master import i2cm_pkg::*; #(
    parameter int RATE_W    = 8,
    parameter int HALF_BASE = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_in,
    output logic             irq
);
    localparam int MAX_SHIFT = 2 * ((1 << PRESC_W) - 1);
    localparam int CNT_W     = RATE_W + MAX_SHIFT + 1;

    logic [RATE_W-1:0]  rate_q;
    logic [PRESC_W-1:0] presc_q;
    logic [7:0]         data_q, code_q;
    ctrl_t              ctrl_q;
    logic               flag_q, busy_q, addr_next_q, rd_mode_q;
    act_e               act_q, act_req;
    logic               ctrl_wr, launch, en_eff;
    logic               eng_done, eng_ack;
    logic [7:0]         eng_rx;
    logic [CNT_W-1:0]   half;

    assign half    = CNT_W'(HALF_BASE) + (CNT_W'(rate_q) << {presc_q, 1'b0});
    assign ctrl_wr = reg_wr && (reg_addr == ADR_CTRL);
    assign en_eff  = ctrl_wr ? reg_wdata[B_EN] : ctrl_q.en;
    assign launch  = ctrl_wr && reg_wdata[B_FLAG] && reg_wdata[B_EN] && !busy_q;
    assign act_req = reg_wdata[B_STA] ? ACT_START : (reg_wdata[B_STO] ? ACT_STOP : ACT_BYTE);
    assign irq     = flag_q && ctrl_q.ie;

    always_comb begin
        unique case (reg_addr)
            ADR_RATE: reg_rdata = REG_W'(rate_q);
            ADR_STAT: reg_rdata = {code_q[7:3], 1'b0, presc_q};
            ADR_DATA: reg_rdata = data_q;
            default:  reg_rdata = {flag_q, ctrl_q.acken, ctrl_q.sta, ctrl_q.sto,
                                   1'b0, ctrl_q.en, 1'b0, ctrl_q.ie};
        endcase
    end

    i2cm_bit_engine #(.CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst(rst), .abort(!en_eff), .go(launch), .act(act_req),
        .tx_byte(data_q), .rx_mode(rd_mode_q && !addr_next_q),
        .ack_en(reg_wdata[B_ACKEN]), .half(half), .sda_in(sda_in),
        .done(eng_done), .ack_seen(eng_ack), .rx_byte(eng_rx),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0; presc_q <= '0; data_q <= '0; code_q <= SC_IDLE;
            ctrl_q <= '0; flag_q <= 1'b0; busy_q <= 1'b0;
            addr_next_q <= 1'b0; rd_mode_q <= 1'b0; act_q <= ACT_START;
        end else begin
            if (reg_wr && reg_addr == ADR_RATE) rate_q  <= reg_wdata[RATE_W-1:0];
            if (reg_wr && reg_addr == ADR_STAT) presc_q <= reg_wdata[PRESC_W-1:0];
            if (reg_wr && reg_addr == ADR_DATA && !busy_q) data_q <= reg_wdata;
            if (ctrl_wr) begin
                ctrl_q <= '{acken: reg_wdata[B_ACKEN], sta: reg_wdata[B_STA],
                            sto: reg_wdata[B_STO], en: reg_wdata[B_EN], ie: reg_wdata[B_IE]};
                if (reg_wdata[B_FLAG]) flag_q <= 1'b0;
            end
            if (launch) begin
                busy_q <= 1'b1;
                act_q  <= act_req;
            end
            if (!en_eff) busy_q <= 1'b0;
            if (eng_done) begin
                flag_q <= 1'b1;
                busy_q <= 1'b0;
                unique case (act_q)
                    ACT_START: begin code_q <= SC_START; addr_next_q <= 1'b1; end
                    ACT_STOP:  begin code_q <= SC_IDLE;  addr_next_q <= 1'b0; end
                    default: begin
                        code_q <= byte_code(addr_next_q, addr_next_q ? data_q[0] : rd_mode_q, eng_ack);
                        if (addr_next_q) begin
                            rd_mode_q   <= data_q[0];
                            addr_next_q <= 1'b0;
                        end else if (rd_mode_q) begin
                            data_q <= eng_rx;
                        end
                    end
                endcase
            end
        end
    end

    // R2: the flag only rises after an engine completion
    p_flag_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(eng_done));
    // R2: every completion leaves the flag set
    p_done_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> flag_q);
    // R8: the data register holds while a step runs, except at its completion
    p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !eng_done) |=> $stable(data_q));
    // R9: a disabled interface leaves both lines released
    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2c_byte_master_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    wire  [7:0] reg_rdata;
    wire        scl_oe, sda_oe, irq;
    logic       slv_pull = 1'b0;
    wire        scl_w = !scl_oe;
    wire        sda_w = !(sda_oe || slv_pull);

    always #2.5 clk = ~clk;

    i2c_byte_master dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w), .irq(irq)
    );

    int n_cmp = 0, n_bad = 0;
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural slave
    logic       live = 1'b0, off = 1'b1, addr_ph = 1'b0, rd = 1'b0, m_ack = 1'b0, slv_ack = 1'b1;
    logic [7:0] sh = 0, got_addr = 0, got_data = 0, tx = 0;
    logic [7:0] rdq[$];
    int         bc = 0;

    always @(negedge sda_w) if (live && scl_w) begin
        bc = 0; addr_ph = 1; off = 0; rd = 0; slv_pull = 0;
    end
    always @(posedge sda_w) if (live && scl_w) begin
        off = 1; slv_pull = 0;
    end
    always @(posedge scl_w) if (live && !off) begin
        if (bc < 8) sh = {sh[6:0], sda_w};
        else if (bc == 8) m_ack = !sda_w;
        bc++;
        if (bc == 8) begin
            if (addr_ph) got_addr = sh;
            else if (!rd) got_data = sh;
        end
    end
    always @(negedge scl_w) if (live && !off) begin
        if (bc == 8) slv_pull = (rd && !addr_ph) ? 1'b0 : slv_ack;
        else if (bc == 9) begin
            bc = 0;
            if (addr_ph) begin
                addr_ph = 0; rd = got_addr[0];
                if (!slv_ack) begin off = 1; slv_pull = 0; end
                else if (rd) begin tx = rdq.pop_front(); slv_pull = !tx[7]; end
                else slv_pull = 0;
            end else if (rd && m_ack) begin
                tx = rdq.pop_front(); slv_pull = !tx[7];
            end else slv_pull = 0;
        end else if (bc >= 1 && bc <= 7 && rd && !addr_ph) slv_pull = !tx[7-bc];
    end

    // line monitor: SCL high widths in bytes, SDA edges under high SCL
    logic hw_en = 1'b0, p_scl = 1'b1, p_sda = 1'b1;
    int   hrun = 0, h_exp = 9, starts = 0, stops = 0, exp_starts = 0, exp_stops = 0;
    always @(negedge clk) if (live) begin
        if (scl_w && p_scl && (sda_w != p_sda)) begin
            if (!sda_w) starts++; else stops++;
        end
        if (scl_w) hrun++;
        else begin
            if (hw_en && hrun != 0) check("R3 scl high width", hrun, h_exp);
            hrun = 0;
        end
        p_scl = scl_w; p_sda = sda_w;
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); reg_addr = a; #1; v = reg_rdata;
    endtask

    // cycle-by-cycle model of flag and interrupt around one launched step
    task automatic run_act(input logic [7:0] ctrl, input int phases, input int h,
                           input int wr_at, input logic [7:0] wv);
        logic exp_f;
        if (ctrl[5]) exp_starts++; else if (ctrl[4]) exp_stops++;
        @(negedge clk); reg_addr = 2'd3; reg_wr = 1'b1; reg_wdata = ctrl;
        @(negedge clk); reg_wr = 1'b0;
        for (int i = 0; i <= phases * h + 2; i++) begin
            if (i > 0) @(negedge clk);
            if (i == wr_at + 1) begin reg_addr = 2'd3; reg_wr = 1'b0; end
            #1;
            exp_f = (i >= phases * h + 1);
            if (i != wr_at + 1 || wr_at < 0) check("R2 flag timing", reg_rdata[7], exp_f);
            check("R7 irq", irq, exp_f && ctrl[0]);
            if (i == wr_at) begin reg_addr = 2'd2; reg_wr = 1'b1; reg_wdata = wv; end
        end
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string tag);
        logic [7:0] v;
        rd_reg(a, v);
        check(tag, v, e);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        live = 1'b1;
        // R11 reset state
        expect_reg(2'd0, 8'h00, "R11 rate after reset");
        expect_reg(2'd1, 8'hF8, "R11 status after reset");
        expect_reg(2'd2, 8'h00, "R11 data after reset");
        expect_reg(2'd3, 8'h00, "R11 control after reset");
        check("R11 lines released", {scl_oe, sda_oe, irq}, 3'b000);

        // R3 bit-rate settings: 0x48/presc 1 -> H=80, 0x03/presc 4 -> H=20
        wr(2'd0, 8'h48); wr(2'd1, 8'h00);
        run_act(8'hA4, 3, 80, -1, 0);
        expect_reg(2'd1, 8'h08, "R4 start code");
        wr(2'd0, 8'h03); wr(2'd1, 8'h01);
        run_act(8'h95, 3, 20, -1, 0);
        expect_reg(2'd1, 8'hF9, "R4 stop code with prescaler field");
        // R2 a control write without bit 7 keeps the flag; R7 follows enable
        wr(2'd3, 8'h05);
        expect_reg(2'd3, 8'h85, "R2 flag kept on write without bit 7");
        check("R7 irq with flag and enable", irq, 1'b1);
        wr(2'd3, 8'h04);
        check("R7 irq masked", irq, 1'b0);

        // write transfer with H=9
        wr(2'd0, 8'h01); wr(2'd1, 8'h00);
        run_act(8'hA4, 3, 9, -1, 0);
        expect_reg(2'd1, 8'h08, "R4 start code");
        wr(2'd2, 8'h44);
        hw_en = 1'b1;
        run_act(8'h84, 18, 9, -1, 0);
        hw_en = 1'b0;
        expect_reg(2'd1, 8'h18, "R4 write address ACK");
        check("R1 address byte on bus", got_addr, 8'h44);
        wr(2'd2, 8'h55);
        run_act(8'h85, 18, 9, 20, 8'hAA);
        expect_reg(2'd1, 8'h28, "R4 data ACK");
        expect_reg(2'd2, 8'h55, "R8 data write during transfer ignored");
        check("R1 data byte on bus", got_data, 8'h55);
        slv_ack = 1'b0;
        wr(2'd2, 8'h3C);
        run_act(8'h84, 18, 9, -1, 0);
        slv_ack = 1'b1;
        expect_reg(2'd1, 8'h30, "R4 data NACK");
        check("R1 second data byte on bus", got_data, 8'h3C);
        run_act(8'h94, 3, 9, -1, 0);
        expect_reg(2'd1, 8'hF8, "R4 stop code");

        // read transfer
        rdq.push_back(8'h66); rdq.push_back(8'h77);
        run_act(8'hA4, 3, 9, -1, 0);
        wr(2'd2, 8'hA1);
        run_act(8'h84, 18, 9, -1, 0);
        expect_reg(2'd1, 8'h40, "R5 read address ACK");
        run_act(8'hC5, 18, 9, -1, 0);
        expect_reg(2'd1, 8'h50, "R6 received with ACK");
        expect_reg(2'd2, 8'h66, "R6 first received byte");
        check("R6 master ACK on bus", m_ack, 1'b1);
        run_act(8'h84, 18, 9, -1, 0);
        expect_reg(2'd1, 8'h58, "R6 received with NACK");
        expect_reg(2'd2, 8'h77, "R6 second received byte");
        check("R6 master NACK on bus", m_ack, 1'b0);
        run_act(8'h94, 3, 9, -1, 0);
        expect_reg(2'd1, 8'hF8, "R4 stop after read");

        // address NACK cases, repeated START
        run_act(8'hA4, 3, 9, -1, 0);
        slv_ack = 1'b0;
        wr(2'd2, 8'hA1);
        run_act(8'h85, 18, 9, -1, 0);
        expect_reg(2'd1, 8'h48, "R5 read address NACK");
        slv_ack = 1'b1;
        run_act(8'hA4, 3, 9, -1, 0);
        expect_reg(2'd1, 8'h08, "R4 repeated start code");
        slv_ack = 1'b0;
        wr(2'd2, 8'h44);
        run_act(8'h84, 18, 9, -1, 0);
        expect_reg(2'd1, 8'h20, "R4 write address NACK");
        slv_ack = 1'b1;
        run_act(8'h94, 3, 9, -1, 0);
        check("R10 START edges", starts, exp_starts);
        check("R10 STOP edges", stops, exp_stops);

        // R9 abort in the middle of a byte
        run_act(8'hA4, 3, 9, -1, 0);
        wr(2'd2, 8'h44);
        @(negedge clk); reg_addr = 2'd3; reg_wr = 1'b1; reg_wdata = 8'h84;
        @(negedge clk); reg_wr = 1'b0;
        repeat (30) @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 8'h00;
        @(negedge clk); reg_wr = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #1;
            if (i == 0 || i == 199) begin
                check("R9 lines released after disable", {scl_oe, sda_oe}, 2'b00);
                check("R9 no completion after disable", reg_rdata[7], 1'b0);
            end else if (scl_oe || sda_oe || reg_rdata[7]) begin
                check("R9 quiet after disable", {scl_oe, sda_oe, reg_rdata[7]}, 3'b000);
            end
        end
        finish_run();
    end
endmodule